// File: doc/BRIEF.md
# Multi-Mode Program Bank Address Mapper

This block translates the upper bits of an 8-bit CPU's 16-bit address into bank addresses for a cartridge program ROM and a battery-backed work RAM. The CPU space from $6000 up is divided into windows. A two-bit layout register sets how many windows cover $8000-$FFFF and how large they are. Each window takes its bank number from a byte-wide bank register. A larger window takes CPU A13, or A14 and A13, in place of the low bank bits. The top bit of a register chooses whether its window reaches RAM or ROM.

The registers sit on the same CPU bus in page $51. A write is captured while the bus strobe is high and is committed on the clock edge that first sees the strobe low. Two key registers must both hold their unlock patterns before any RAM write strobe can reach the RAM. The translation outputs are combinational from the current CPU address, so a bank change shows on the next access.

Top module: `pbank_mapper`

## Requirements
- R1: After reset the layout is four 8 KB windows (layout code 3), the four bank registers for $8000, $A000, $C000 and $E000 hold $FF (ROM bank $7F), the RAM bank register holds 0, and both keys are cleared, so ram_we stays low.
- R2: An access to $6000-$7FFF asserts ram_ce and not rom_ce, and ram_addr equals bits 3..0 of the RAM bank register. ram_addr bit 2 acts as the RAM chip select.
- R3: An access below $6000 asserts neither rom_ce nor ram_ce.
- R4: Layout 3 uses four 8 KB windows taken from registers $5114, $5115, $5116 and $5117 in address order. For $5114-$5116, bit 7 = 1 selects ROM with rom_addr = bits 6..0, and bit 7 = 0 selects RAM with ram_addr = bits 3..0. The $E000 window ($5117) is always ROM.
- R5: Layout 2 maps $8000-$BFFF through $5115 with bank bit 0 replaced by CPU A13, $C000-$DFFF through $5116, and $E000-$FFFF through $5117 as ROM.
- R6: Layout 1 maps $8000-$BFFF through $5115 and $C000-$FFFF through $5117, which is always ROM. In both windows bank bit 0 is replaced by CPU A13.
- R7: Layout 0 maps $8000-$FFFF as ROM through $5117, with bank bits 1 and 0 replaced by CPU A14 and A13.
- R8: ram_we is high only when ram_ce, cpu_wr and cpu_strobe are all high, bits 1..0 of key register $5102 equal binary 10, and bits 1..0 of key register $5103 equal binary 01. The upper key bits are ignored.
- R9: Register writes (layout $5100 bits 1..0, keys $5102/$5103, RAM bank $5113, bank registers $5114-$5117) take effect after the strobe falls. A write to any other address, including $5101, $5104-$5112, $5118 and addresses outside page $51, changes no mapping.
- R10: In layouts 0, 1 and 2, register $5114 has no effect on any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | 1 for a CPU write cycle |
| cpu_strobe | input | 1 | Bus strobe, high during the data phase |
| rom_addr | output | 7 | ROM address bits A19..A13 |
| ram_addr | output | 4 | RAM address bits A16..A13 (bit 2 is the chip select) |
| rom_ce | output | 1 | ROM chip enable, active high |
| ram_ce | output | 1 | RAM chip enable, active high |
| ram_we | output | 1 | RAM write enable, active high |

## Verification
The assertions check four rules on every cycle: the two chip enables are never both high; the region below $6000 enables nothing; $6000 always reaches RAM and $E000 always reaches ROM; and a RAM write strobe never appears without an enabled RAM, a write strobe and both unlock keys. They also check that the mapping registers change only after a strobe falls. Only the bench's scenarios show that the bank numbers land in the correct window in each layout, that CPU A13/A14 substitute correctly, and that writes to unused register addresses leave the mapping alone.

// File: rtl/pbank_pkg.sv
package pbank_pkg;

    localparam int BANK_W   = 8;
    localparam int NUM_WIN  = 4;
    localparam int ROM_AW   = 7;
    localparam int RAM_AW   = 4;

    localparam logic [7:0] OFF_LAYOUT  = 8'h00;
    localparam logic [7:0] OFF_KEY_A   = 8'h02;
    localparam logic [7:0] OFF_KEY_B   = 8'h03;
    localparam logic [7:0] OFF_RAMBANK = 8'h13;
    localparam logic [7:0] OFF_WIN0    = 8'h14;

    localparam logic [1:0] KEY_A_OPEN = 2'b10;
    localparam logic [1:0] KEY_B_OPEN = 2'b01;

    typedef enum logic [1:0] {
        PM_ONE32  = 2'd0,
        PM_TWO16  = 2'd1,
        PM_MIXED  = 2'd2,
        PM_FOUR8  = 2'd3
    } pmode_e;

    typedef struct packed {
        pmode_e           layout;
        logic [1:0]       key_a;
        logic [1:0]       key_b;
        logic [RAM_AW-1:0] ram_bank;
    } cfg_t;

    // Which register drives a region and how many low bank bits the CPU supplies
    typedef struct packed {
        logic       in_ram_win;
        logic       in_prg;
        logic [1:0] reg_idx;
        logic [1:0] cpu_bits;
    } route_t;

    function automatic route_t route_of(input pmode_e m, input logic [2:0] top);
        route_t r;
        r = '0;
        if (top == 3'd3) begin
            r.in_ram_win = 1'b1;
        end else if (top[2]) begin
            r.in_prg = 1'b1;
            unique case (m)
                PM_ONE32: begin r.reg_idx = 2'd3; r.cpu_bits = 2'd2; end
                PM_TWO16: begin r.reg_idx = top[1] ? 2'd3 : 2'd1; r.cpu_bits = 2'd1; end
                PM_MIXED: begin
                    if (!top[1]) begin r.reg_idx = 2'd1; r.cpu_bits = 2'd1; end
                    else         begin r.reg_idx = top[1:0]; r.cpu_bits = 2'd0; end
                end
                default:  begin r.reg_idx = top[1:0]; r.cpu_bits = 2'd0; end
            endcase
        end
        return r;
    endfunction

    function automatic logic [BANK_W-1:0] splice(input logic [BANK_W-1:0] bank,
                                                input logic [1:0] cpu_bits,
                                                input logic a14, input logic a13);
        logic [BANK_W-1:0] o;
        o = bank;
        if (cpu_bits != 2'd0) o[0] = a13;
        if (cpu_bits == 2'd2) o[1] = a14;
        return o;
    endfunction

endpackage

// File: rtl/pbank_regs.sv
module pbank_regs
    import pbank_pkg::*;
#(
    parameter logic [7:0]        REG_PAGE   = 8'h51,
    parameter logic [BANK_W-1:0] BANK_RST   = 8'hFF,
    parameter pmode_e            LAYOUT_RST = PM_FOUR8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [15:0]                   addr,
    input  logic [BANK_W-1:0]             wdata,
    input  logic                          wr,
    input  logic                          strobe,
    output cfg_t                          cfg,
    output logic [NUM_WIN-1:0][BANK_W-1:0] banks
);
    logic              strobe_q;
    logic              cap_wr;
    logic [15:0]       cap_addr;
    logic [BANK_W-1:0] cap_data;
    logic              commit;
    logic [7:0]        off;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            cap_wr   <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            strobe_q <= strobe;
            if (strobe) begin
                cap_wr   <= wr;
                cap_addr <= addr;
                cap_data <= wdata;
            end
        end
    end

    assign off    = cap_addr[7:0];
    assign commit = strobe_q && !strobe && cap_wr && (cap_addr[15:8] == REG_PAGE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.layout   <= LAYOUT_RST;
            cfg.key_a    <= '0;
            cfg.key_b    <= '0;
            cfg.ram_bank <= '0;
        end else if (commit) begin
            unique case (off)
                OFF_LAYOUT:  cfg.layout   <= pmode_e'(cap_data[1:0]);
                OFF_KEY_A:   cfg.key_a    <= cap_data[1:0];
                OFF_KEY_B:   cfg.key_b    <= cap_data[1:0];
                OFF_RAMBANK: cfg.ram_bank <= cap_data[RAM_AW-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_bank
        localparam logic [7:0] MY_OFF = OFF_WIN0 + 8'(i);
        always_ff @(posedge clk) begin
            if (rst)                           banks[i] <= BANK_RST;
            else if (commit && off == MY_OFF)  banks[i] <= cap_data;
        end
    end

endmodule

// File: rtl/pbank_window.sv
module pbank_window
    import pbank_pkg::*;
(
    input  pmode_e                         layout,
    input  logic [RAM_AW-1:0]              ram_bank,
    input  logic [NUM_WIN-1:0][BANK_W-1:0] banks,
    input  logic [2:0]                     top,
    output logic [ROM_AW-1:0]              rom_addr,
    output logic [RAM_AW-1:0]              ram_addr,
    output logic                           rom_sel,
    output logic                           ram_sel
);
    route_t            rt;
    logic [BANK_W-1:0] spl;
    logic              is_rom;

    always_comb begin
        rt     = route_of(layout, top);
        spl    = splice(banks[rt.reg_idx], rt.cpu_bits, top[1], top[0]);
        is_rom = (rt.reg_idx == 2'd3) || spl[BANK_W-1];

        rom_addr = spl[ROM_AW-1:0];
        ram_addr = ram_bank;
        rom_sel  = 1'b0;
        ram_sel  = 1'b0;
        if (rt.in_ram_win) begin
            ram_sel = 1'b1;
        end else if (rt.in_prg) begin
            rom_sel  = is_rom;
            ram_sel  = !is_rom;
            ram_addr = spl[RAM_AW-1:0];
        end
    end

endmodule

// File: rtl/pbank_gate.sv
module pbank_gate
    import pbank_pkg::*;
(
    input  logic       rom_sel,
    input  logic       ram_sel,
    input  logic [1:0] key_a,
    input  logic [1:0] key_b,
    input  logic       wr,
    input  logic       strobe,
    output logic       rom_ce,
    output logic       ram_ce,
    output logic       ram_we
);
    logic unlocked;

    assign unlocked = (key_a == KEY_A_OPEN) && (key_b == KEY_B_OPEN);
    assign rom_ce   = rom_sel;
    assign ram_ce   = ram_sel;
    assign ram_we   = ram_sel && wr && strobe && unlocked;

endmodule

// File: rtl/pbank_mapper.sv
module pbank_mapper
    import pbank_pkg::*;
#(
    parameter logic [7:0]        REG_PAGE   = 8'h51,
    parameter logic [BANK_W-1:0] BANK_RST   = 8'hFF,
    parameter pmode_e            LAYOUT_RST = PM_FOUR8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_strobe,
    output logic [6:0]        rom_addr,
    output logic [3:0]        ram_addr,
    output logic              rom_ce,
    output logic              ram_ce,
    output logic              ram_we
);
    cfg_t                           cfg;
    logic [NUM_WIN-1:0][BANK_W-1:0] banks;
    logic                           rom_sel;
    logic                           ram_sel;

    pbank_regs #(
        .REG_PAGE   (REG_PAGE),
        .BANK_RST   (BANK_RST),
        .LAYOUT_RST (LAYOUT_RST)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .wr     (cpu_wr),
        .strobe (cpu_strobe),
        .cfg    (cfg),
        .banks  (banks)
    );

    pbank_window u_window (
        .layout   (cfg.layout),
        .ram_bank (cfg.ram_bank),
        .banks    (banks),
        .top      (cpu_addr[15:13]),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr),
        .rom_sel  (rom_sel),
        .ram_sel  (ram_sel)
    );

    pbank_gate u_gate (
        .rom_sel (rom_sel),
        .ram_sel (ram_sel),
        .key_a   (cfg.key_a),
        .key_b   (cfg.key_b),
        .wr      (cpu_wr),
        .strobe  (cpu_strobe),
        .rom_ce  (rom_ce),
        .ram_ce  (ram_ce),
        .ram_we  (ram_we)
    );

endmodule

// File: rtl/pbank_mapper_chk.sv
module pbank_mapper_chk
    import pbank_pkg::*;
(
    input logic                           clk,
    input logic                           rst,
    input logic [15:0]                    cpu_addr,
    input logic                           cpu_wr,
    input logic                           cpu_strobe,
    input logic                           rom_ce,
    input logic                           ram_ce,
    input logic                           ram_we,
    input cfg_t                           cfg,
    input logic [NUM_WIN-1:0][BANK_W-1:0] banks
);
    logic strobe_prev;

    always_ff @(posedge clk) begin
        if (rst) strobe_prev <= 1'b0;
        else     strobe_prev <= cpu_strobe;
    end

    a_r4_ce_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rom_ce && ram_ce));

    a_r3_low_region_idle: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] < 3'd3) |-> (!rom_ce && !ram_ce));

    a_r2_ram_window: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'd3) |-> (ram_ce && !rom_ce));

    a_r4_top_window_rom: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'd7) |-> rom_ce);

    a_r8_we_qualified: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_ce && cpu_wr && cpu_strobe));

    a_r8_we_keys: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cfg.key_a == KEY_A_OPEN && cfg.key_b == KEY_B_OPEN));

    // R9: mapping state moves only on the edge after a strobe fall
    a_r9_commit_on_fall: assert property (@(posedge clk) disable iff (rst)
        !(strobe_prev && !cpu_strobe) |=> ($stable(cfg) && $stable(banks)));

endmodule

bind pbank_mapper pbank_mapper_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .cpu_strobe (cpu_strobe),
    .rom_ce     (rom_ce),
    .ram_ce     (ram_ce),
    .ram_we     (ram_we),
    .cfg        (cfg),
    .banks      (banks)
);

// File: tb/pbank_mapper_bench.sv
module pbank_mapper_bench;

    typedef struct {
        logic [15:0] a;
        logic        rom_ce;
        logic        ram_ce;
        logic        we;
        logic [6:0]  ra;
        logic [3:0]  wa;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_strobe = 1'b0;
    logic [6:0]  rom_addr;
    logic [3:0]  ram_addr;
    logic        rom_ce, ram_ce, ram_we;

    int errors = 0;
    int checks = 0;
    bit timed_out = 0;
    exp_t q[$];

    // shadow of what the bench has programmed
    logic [1:0] sh_layout = 2'd3;
    logic [1:0] sh_ka = 2'd0, sh_kb = 2'd0;
    logic [3:0] sh_ram = 4'd0;
    logic [7:0] sh_win [4] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};

    always #4 clk = ~clk;

    pbank_mapper u_pbank_mapper (
        .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
        .cpu_wr (cpu_wr), .cpu_strobe (cpu_strobe), .rom_addr (rom_addr),
        .ram_addr (ram_addr), .rom_ce (rom_ce), .ram_ce (ram_ce), .ram_we (ram_we)
    );

    function automatic exp_t model(input logic [15:0] a, input logic wr, input logic stb);
        exp_t e;
        logic [7:0] b;
        logic rom;
        e.a = a; e.rom_ce = 0; e.ram_ce = 0; e.we = 0; e.ra = '0; e.wa = '0; e.tag = "";
        b = 8'h00; rom = 0;
        if (a < 16'h6000) return e;
        if (a < 16'h8000) begin
            e.ram_ce = 1; e.wa = sh_ram;
        end else begin
            if (sh_layout == 2'd0) begin
                b = sh_win[3]; b[1] = a[14]; b[0] = a[13]; rom = 1;
            end else if (sh_layout == 2'd1) begin
                if (a < 16'hC000) begin b = sh_win[1]; rom = b[7]; end
                else              begin b = sh_win[3]; rom = 1; end
                b[0] = a[13];
            end else if (sh_layout == 2'd2) begin
                if (a < 16'hC000)      begin b = sh_win[1]; b[0] = a[13]; rom = b[7]; end
                else if (a < 16'hE000) begin b = sh_win[2]; rom = b[7]; end
                else                   begin b = sh_win[3]; rom = 1; end
            end else begin
                b = sh_win[a[14:13]];
                rom = (a >= 16'hE000) ? 1'b1 : b[7];
            end
            e.rom_ce = rom; e.ram_ce = !rom;
            e.ra = b[6:0]; e.wa = b[3:0];
        end
        e.we = e.ram_ce && wr && stb && sh_ka == 2'b10 && sh_kb == 2'b01;
        return e;
    endfunction

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1; cpu_strobe = 1;
        @(negedge clk);
        cpu_strobe = 0; cpu_wr = 0;
        @(negedge clk);
        case (a)
            16'h5100: sh_layout = d[1:0];
            16'h5102: sh_ka = d[1:0];
            16'h5103: sh_kb = d[1:0];
            16'h5113: sh_ram = d[3:0];
            16'h5114: sh_win[0] = d;
            16'h5115: sh_win[1] = d;
            16'h5116: sh_win[2] = d;
            16'h5117: sh_win[3] = d;
            default: ;
        endcase
    endtask

    task automatic probe(input logic [15:0] a, input logic wr, input logic stb, input string tag);
        exp_t e;
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_strobe = stb;
        e = model(a, wr, stb);
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares one expected item per cycle, just after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                bit bad;
                e = q.pop_front();
                checks++;
                bad = (rom_ce !== e.rom_ce) || (ram_ce !== e.ram_ce) || (ram_we !== e.we);
                if (e.rom_ce && rom_addr !== e.ra) bad = 1;
                if (e.ram_ce && ram_addr !== e.wa) bad = 1;
                if (bad) begin
                    errors++;
                    $display("FAIL %s addr=%h actual rom_ce=%b ram_ce=%b we=%b rom=%h ram=%h expected rom_ce=%b ram_ce=%b we=%b rom=%h ram=%h",
                             e.tag, e.a, rom_ce, ram_ce, ram_we, rom_addr, ram_addr,
                             e.rom_ce, e.ram_ce, e.we, e.ra, e.wa);
                end
            end
        end
    end

    function automatic string tag_for(input int layout, input int region);
        if (region < 3)  return "R3";
        if (region == 3) return "R2";
        case (layout)
            0: return "R7";
            1: return "R6";
            2: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic sweep_all_layouts();
        for (int m = 3; m >= 0; m--) begin
            reg_write(16'h5100, 8'(m));
            for (int r = 0; r < 8; r++)
                probe(16'((r << 13) | 16'h0ABC), 1'b0, 1'b0, tag_for(m, r));
        end
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: power-on state
        probe(16'hE000, 0, 0, "R1");
        probe(16'h8123, 0, 0, "R1");
        probe(16'hA000, 0, 0, "R1");
        probe(16'h6010, 1, 1, "R1");

        // R9: writes to unused addresses leave the mapping unchanged
        reg_write(16'h5101, 8'h00);
        reg_write(16'h5104, 8'h00);
        reg_write(16'h5112, 8'h00);
        reg_write(16'h5118, 8'h00);
        reg_write(16'h4114, 8'h00);
        reg_write(16'h5214, 8'h00);
        probe(16'h8000, 0, 0, "R9");
        probe(16'hC000, 0, 0, "R9");
        probe(16'hE000, 0, 0, "R9");

        // first bank set
        reg_write(16'h5113, 8'h0E);
        reg_write(16'h5114, 8'h05);
        reg_write(16'h5115, 8'hA3);
        reg_write(16'h5116, 8'h4A);
        reg_write(16'h5117, 8'h3D);
        sweep_all_layouts();

        // second bank set with RAM/ROM choices flipped
        reg_write(16'h5113, 8'h03);
        reg_write(16'h5114, 8'h9C);
        reg_write(16'h5115, 8'h36);
        reg_write(16'h5116, 8'hC1);
        reg_write(16'h5117, 8'hF2);
        sweep_all_layouts();

        // R10: $5114 ignored outside layout 3
        for (int m = 0; m < 3; m++) begin
            reg_write(16'h5100, 8'(m));
            reg_write(16'h5114, 8'h01);
            probe(16'h8000, 0, 0, "R10");
            probe(16'hA000, 0, 0, "R10");
            reg_write(16'h5114, 8'hFE);
            probe(16'h8000, 0, 0, "R10");
            probe(16'h9FFF, 0, 0, "R10");
        end

        // R8: RAM write keys
        reg_write(16'h5100, 8'h03);
        reg_write(16'h5114, 8'h02);
        probe(16'h8000, 1, 1, "R8");
        reg_write(16'h5102, 8'h02);
        probe(16'h8000, 1, 1, "R8");
        reg_write(16'h5103, 8'h01);
        probe(16'h8000, 1, 1, "R8");
        probe(16'h6400, 1, 1, "R8");
        probe(16'h8000, 0, 1, "R8");
        probe(16'h8000, 1, 0, "R8");
        probe(16'hE000, 1, 1, "R8");
        probe(16'h4000, 1, 1, "R8");
        reg_write(16'h5102, 8'h06);
        reg_write(16'h5103, 8'hF5);
        probe(16'h8000, 1, 1, "R8");
        reg_write(16'h5102, 8'h01);
        reg_write(16'h5103, 8'h02);
        probe(16'h8000, 1, 1, "R8");
        probe(16'h0000, 0, 0, "R3");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual hung run, expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule